// File: doc/BRIEF.md
# Exception and Status Control Unit

This block is the system-control slice of a 32-bit in-order core. It holds the status word, the cause word, the saved exception return address and four breakpoint storage words. When the pipeline reports a fault, the block saves the return address and writes the cause. It pushes a three-level stack of kernel/user and interrupt-enable bit pairs, picks the handler address and pulses a flush toward the pipeline.

The block also serves coprocessor-0 register moves. A move-to write merges the new value under a fixed mask for each register. A move-from read comes back through the delayed-load path one cycle later. The return-from-exception operation pops the mode stack. Before it performs any coprocessor operation, the block checks that the operation is permitted. A refused operation becomes an exception instead.

All state changes at the clock edge where the request is presented. `flushPipe`, `vectorPc`, `ldValid`, `ldReg` and `ldData` are registered, so they show the result in the following cycle.

Top module: `sysctl_unit`

## Requirements
- R1: After reset, `flushPipe` and `ldValid` are 0, and reads of status (register 12), cause (register 13) and return address (register 14) return 0.
- R2: When an exception is taken, the saved return address becomes `instPc`. If `instInSlot` is 1, it becomes `instPc` minus 4 instead.
- R3: When an exception is taken, cause bits [6:2] take the exception code and cause bit 31 takes `instInSlot`. All other cause bits keep their values.
- R4: When an exception is taken, status bits [5:0] become {old [3:0], 2'b00}. All other status bits are unchanged.
- R5: A return-from-exception operation (`copOp`=2) keeps status bits [5:4] and loads status bits [3:0] with the old bits [5:2]. It causes no flush.
- R6: In the cycle after an exception is taken, `flushPipe` is 1 for one cycle. In that cycle `vectorPc` is 0xBFC00180 if status bit 22 was 1, and 0x80000080 otherwise.
- R7: A move-to (`copOp`=0) changes only the bits set in that register's write mask: status 0xF27FFF3F, cause 0x00000300, register 7 0xFF80F03F. Registers 3, 5, 9 and 11 take the full word. Writes to register 14 and to unlisted numbers have no effect.
- R8: A move-from (`copOp`=1) raises `ldValid` in the next cycle only. In that cycle `ldReg`=`copRt` and `ldData` holds the register value, which is 0 for unlisted numbers.
- R9: A unit-0 operation issued while status bit 1 is 1 (user mode) and status bit 28 is 0 is not performed. It raises an exception with code 11.
- R10: An operation on `copUnit` 1, 2 or 3 is never performed and always raises an exception with code 11. `copOp`=3 is ignored on every unit.
- R11: If `excReq` and a coprocessor operation arrive in the same cycle, the request is taken with its own code and the operation is dropped. In particular, no register write and no `ldValid` result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | Pipeline exception request |
| excCode | input | 5 | Exception code for the request |
| instPc | input | 32 | PC of the instruction presented this cycle |
| instInSlot | input | 1 | That instruction sits in a branch delay slot |
| copValid | input | 1 | Coprocessor operation present |
| copUnit | input | 2 | Target coprocessor number |
| copOp | input | 2 | 0 move-to, 1 move-from, 2 return-from-exception, 3 none |
| copReg | input | 5 | Control register number |
| copRt | input | 5 | General register receiving a move-from |
| copWrData | input | 32 | Move-to data |
| flushPipe | output | 1 | Flush pulse, cancels pipeline load-delay state |
| vectorPc | output | 32 | Handler address, valid with flushPipe |
| ldValid | output | 1 | Delayed-load result valid |
| ldReg | output | 5 | Delayed-load destination |
| ldData | output | 32 | Delayed-load data |

## Verification
A pipeline exception request can land in the same cycle as a coprocessor move. The bench presents `excReq` together with a move-to to a breakpoint register, and then together with a move-from. It judges the outcome from three things: a flush pulse appears, the cause code is the request's own code and not 11, the breakpoint register still reads its old value and no `ldValid` result appears. A refused coprocessor operation is an internal collision of a different kind. The bench checks it by reading back the target register after the resulting exception.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int WORD_W = 32;
  localparam int MODE_W = 6;
  localparam int NDBG   = 4;

  // control register numbers decoded by the move path
  localparam logic [4:0] REG_DCTL  = 5'd7;
  localparam logic [4:0] REG_STAT  = 5'd12;
  localparam logic [4:0] REG_CAUSE = 5'd13;
  localparam logic [4:0] REG_RET   = 5'd14;

  // field positions
  localparam int ST_USER = 1;
  localparam int ST_BEV  = 22;
  localparam int ST_CU0  = 28;
  localparam int CA_BD   = 31;
  localparam int CA_CODE = 2;

  localparam logic [4:0] CODE_UNUSABLE = 5'd11;

  typedef enum logic [1:0] {
    OP_MOVE_TO   = 2'd0,
    OP_MOVE_FROM = 2'd1,
    OP_RETURN    = 2'd2,
    OP_NONE      = 2'd3
  } cop_op_e;

  typedef struct packed {
    logic       takeExc;
    logic [4:0] code;
    logic       doMtc;
    logic       doMfc;
    logic       doRfe;
  } ctl_strobe_t;

  function automatic logic [4:0] dbgIdx(input int i);
    case (i)
      0:       dbgIdx = 5'd3;
      1:       dbgIdx = 5'd5;
      2:       dbgIdx = 5'd9;
      default: dbgIdx = 5'd11;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        excReq,
  input  logic [4:0]  excCode,
  input  logic        copValid,
  input  logic [1:0]  copUnit,
  input  logic [1:0]  copOp,
  input  logic        userMode,
  input  logic        cu0Ok,
  output ctl_strobe_t stb
);
  logic isCop;
  logic denied;
  logic allowed;

  always_comb begin
    isCop   = copValid && (copOp != OP_NONE);
    denied  = isCop && ((copUnit != 2'd0) || (userMode && !cu0Ok));
    allowed = isCop && !denied && !excReq;
    stb.takeExc = excReq || denied;
    stb.code    = excReq ? excCode : CODE_UNUSABLE;
    stb.doMtc   = allowed && (copOp == OP_MOVE_TO);
    stb.doMfc   = allowed && (copOp == OP_MOVE_FROM);
    stb.doRfe   = allowed && (copOp == OP_RETURN);
  end

  // R11
  exc_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    excReq |-> (!stb.doMtc && !stb.doMfc && !stb.doRfe && stb.code == excCode));

  // R9
  cu0_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (copValid && copOp != OP_NONE && copUnit == 2'd0 && userMode && !cu0Ok && !excReq)
      |-> (stb.takeExc && stb.code == CODE_UNUSABLE));

  // R10
  other_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (copValid && copUnit != 2'd0) |-> (!stb.doMtc && !stb.doMfc && !stb.doRfe));

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.takeExc, stb.doMtc, stb.doMfc, stb.doRfe}));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter logic [WORD_W-1:0] STAT_WMASK  = 32'hF27F_FF3F,
  parameter logic [WORD_W-1:0] CAUSE_WMASK = 32'h0000_0300,
  parameter logic [WORD_W-1:0] DCTL_WMASK  = 32'hFF80_F03F,
  parameter logic [WORD_W-1:0] VEC_BOOT    = 32'hBFC0_0180,
  parameter logic [WORD_W-1:0] VEC_MAIN    = 32'h8000_0080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_strobe_t       stb,
  input  logic [WORD_W-1:0] instPc,
  input  logic              instInSlot,
  input  logic [4:0]        copReg,
  input  logic [4:0]        copRt,
  input  logic [WORD_W-1:0] copWrData,
  output logic              userMode,
  output logic              cu0Ok,
  output logic              flushPipe,
  output logic [WORD_W-1:0] vectorPc,
  output logic              ldValid,
  output logic [4:0]        ldReg,
  output logic [WORD_W-1:0] ldData
);
  logic [WORD_W-1:0] statQ, causeQ, retQ, dctlQ;
  logic [WORD_W-1:0] dbgQ [NDBG];
  logic [WORD_W-1:0] rdVal;

  assign userMode = statQ[ST_USER];
  assign cu0Ok    = statQ[ST_CU0];

  always_comb begin
    rdVal = '0;
    case (copReg)
      REG_STAT:  rdVal = statQ;
      REG_CAUSE: rdVal = causeQ;
      REG_RET:   rdVal = retQ;
      REG_DCTL:  rdVal = dctlQ;
      default:   rdVal = '0;
    endcase
    for (int i = 0; i < NDBG; i++)
      if (copReg == dbgIdx(i)) rdVal = dbgQ[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statQ     <= '0;
      causeQ    <= '0;
      retQ      <= '0;
      dctlQ     <= '0;
      flushPipe <= 1'b0;
      vectorPc  <= '0;
      ldValid   <= 1'b0;
      ldReg     <= '0;
      ldData    <= '0;
    end else begin
      flushPipe <= stb.takeExc;
      ldValid   <= stb.doMfc;
      if (stb.takeExc) begin
        retQ                        <= instInSlot ? (instPc - 32'd4) : instPc;
        causeQ[CA_CODE+4:CA_CODE]   <= stb.code;
        causeQ[CA_BD]               <= instInSlot;
        statQ[MODE_W-1:0]           <= {statQ[MODE_W-3:0], 2'b00};
        vectorPc                    <= statQ[ST_BEV] ? VEC_BOOT : VEC_MAIN;
      end
      if (stb.doMtc) begin
        case (copReg)
          REG_STAT:  statQ  <= (statQ  & ~STAT_WMASK)  | (copWrData & STAT_WMASK);
          REG_CAUSE: causeQ <= (causeQ & ~CAUSE_WMASK) | (copWrData & CAUSE_WMASK);
          REG_DCTL:  dctlQ  <= (dctlQ  & ~DCTL_WMASK)  | (copWrData & DCTL_WMASK);
          default: ;
        endcase
      end
      if (stb.doRfe)
        statQ[MODE_W-1:0] <= {statQ[MODE_W-1:MODE_W-2], statQ[MODE_W-1:2]};
      if (stb.doMfc) begin
        ldReg  <= copRt;
        ldData <= rdVal;
      end
    end
  end

  for (genvar g = 0; g < NDBG; g++) begin : g_dbg
    always_ff @(posedge clk) begin
      if (!rst_n)
        dbgQ[g] <= '0;
      else if (stb.doMtc && copReg == dbgIdx(g))
        dbgQ[g] <= copWrData;
    end
  end

  // R4
  mode_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.takeExc |=> (statQ[5:2] == $past(statQ[3:0]) && statQ[1:0] == 2'b00
                     && statQ[31:6] == $past(statQ[31:6])));

  // R5
  mode_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.doRfe |=> (statQ[5:4] == $past(statQ[5:4]) && statQ[3:0] == $past(statQ[5:2])));

  // R2
  ret_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.takeExc && instInSlot) |=> (retQ + 32'd4 == $past(instPc)));

  // R7
  ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.takeExc |=> $stable(retQ));

  // R11
  flush_load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flushPipe && ldValid));

  // R8
  ld_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ldValid) |-> $past(stb.doMfc));

  // R6
  flush_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flushPipe |-> (vectorPc == VEC_BOOT || vectorPc == VEC_MAIN));
endmodule

// File: rtl/sysctl_unit.sv
module sysctl_unit
  import sysctl_pkg::*;
#(
  parameter logic [31:0] STAT_WMASK  = 32'hF27F_FF3F,
  parameter logic [31:0] CAUSE_WMASK = 32'h0000_0300,
  parameter logic [31:0] DCTL_WMASK  = 32'hFF80_F03F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        excReq,
  input  logic [4:0]  excCode,
  input  logic [31:0] instPc,
  input  logic        instInSlot,
  input  logic        copValid,
  input  logic [1:0]  copUnit,
  input  logic [1:0]  copOp,
  input  logic [4:0]  copReg,
  input  logic [4:0]  copRt,
  input  logic [31:0] copWrData,
  output logic        flushPipe,
  output logic [31:0] vectorPc,
  output logic        ldValid,
  output logic [4:0]  ldReg,
  output logic [31:0] ldData
);
  ctl_strobe_t stb;
  logic        userMode;
  logic        cu0Ok;

  sysctl_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .excReq   (excReq),
    .excCode  (excCode),
    .copValid (copValid),
    .copUnit  (copUnit),
    .copOp    (copOp),
    .userMode (userMode),
    .cu0Ok    (cu0Ok),
    .stb      (stb)
  );

  sysctl_regs #(
    .STAT_WMASK  (STAT_WMASK),
    .CAUSE_WMASK (CAUSE_WMASK),
    .DCTL_WMASK  (DCTL_WMASK)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .instPc     (instPc),
    .instInSlot (instInSlot),
    .copReg     (copReg),
    .copRt      (copRt),
    .copWrData  (copWrData),
    .userMode   (userMode),
    .cu0Ok      (cu0Ok),
    .flushPipe  (flushPipe),
    .vectorPc   (vectorPc),
    .ldValid    (ldValid),
    .ldReg      (ldReg),
    .ldData     (ldData)
  );
endmodule

// File: tb/tb_sysctl_unit.sv
`timescale 1ns/1ps
module tb_sysctl_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        excReq = 1'b0;
  logic [4:0]  excCode = '0;
  logic [31:0] instPc = '0;
  logic        instInSlot = 1'b0;
  logic        copValid = 1'b0;
  logic [1:0]  copUnit = '0;
  logic [1:0]  copOp = 2'd3;
  logic [4:0]  copReg = '0;
  logic [4:0]  copRt = '0;
  logic [31:0] copWrData = '0;
  logic        flushPipe, ldValid;
  logic [31:0] vectorPc, ldData;
  logic [4:0]  ldReg;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  logic        sFlush, sLdV;
  logic [31:0] sVec, sLdD;
  logic [4:0]  sLdR;

  always #2.5 clk = ~clk;

  sysctl_unit dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idleIn();
    excReq = 0; copValid = 0; copOp = 2'd3; instInSlot = 0;
  endtask

  // drive one cycle of stimulus, then sample the registered response
  task automatic issue(input bit er, input logic [4:0] code, input logic [31:0] pc,
                       input bit slot, input bit cv, input logic [1:0] unit,
                       input logic [1:0] op, input logic [4:0] rg, input logic [31:0] wd);
    @(negedge clk);
    excReq = er; excCode = code; instPc = pc; instInSlot = slot;
    copValid = cv; copUnit = unit; copOp = op; copReg = rg; copRt = 5'd7; copWrData = wd;
    @(negedge clk);
    idleIn();
    sFlush = flushPipe; sVec = vectorPc; sLdV = ldValid; sLdD = ldData; sLdR = ldReg;
  endtask

  task automatic wr(input logic [4:0] rg, input logic [31:0] wd);
    issue(0, 0, 32'h0, 0, 1, 2'd0, 2'd0, rg, wd);
  endtask

  task automatic rd(input string req, input logic [4:0] rg, input logic [31:0] exp);
    issue(0, 0, 32'h0, 0, 1, 2'd0, 2'd1, rg, 32'h0);
    chk({req, " ldValid"}, {31'b0, sLdV}, 32'h1);
    chk({req, " data"}, sLdD, exp);
  endtask

  task automatic tReset();
    @(negedge clk);
    chk("R1 flush", {31'b0, flushPipe}, 0);
    chk("R1 ldValid", {31'b0, ldValid}, 0);
    rd("R1 status", 5'd12, 0);
    rd("R1 cause", 5'd13, 0);
    rd("R1 ret", 5'd14, 0);
  endtask

  task automatic tMasks();
    wr(5'd12, 32'hFFFF_FFFF);
    rd("R7 status mask", 5'd12, 32'hF27F_FF3F);
    wr(5'd12, 32'h0);
    wr(5'd13, 32'hFFFF_FFFF);
    rd("R7 cause mask", 5'd13, 32'h0000_0300);
    wr(5'd7, 32'hFFFF_FFFF);
    rd("R7 reg7 mask", 5'd7, 32'hFF80_F03F);
    wr(5'd14, 32'h1234_5678);
    rd("R7 ret ignored", 5'd14, 0);
    wr(5'd3, 32'hDEAD_BEEF);
    rd("R7 reg3 full", 5'd3, 32'hDEAD_BEEF);
    wr(5'd20, 32'hFFFF_FFFF);
    rd("R8 unlisted reads 0", 5'd20, 0);
  endtask

  task automatic tMfcTiming();
    wr(5'd9, 32'hCAFE_F00D);
    issue(0, 0, 0, 0, 1, 2'd0, 2'd1, 5'd9, 0);
    chk("R8 ldValid next", {31'b0, sLdV}, 1);
    chk("R8 ldReg", {27'b0, sLdR}, 7);
    chk("R8 ldData", sLdD, 32'hCAFE_F00D);
    chk("R8 no flush", {31'b0, sFlush}, 0);
    issue(0, 0, 0, 0, 0, 2'd0, 2'd3, 0, 0);
    chk("R8 ldValid one cycle", {31'b0, sLdV}, 0);
  endtask

  task automatic tExcPlain();
    wr(5'd13, 32'h0000_0100);
    wr(5'd12, 32'h0000_000D);
    issue(1, 5'd8, 32'h8000_1000, 0, 0, 2'd0, 2'd3, 0, 0);
    chk("R6 flush", {31'b0, sFlush}, 1);
    chk("R6 vector main", sVec, 32'h8000_0080);
    issue(0, 0, 0, 0, 0, 2'd0, 2'd3, 0, 0);
    chk("R6 flush one cycle", {31'b0, sFlush}, 0);
    rd("R2 ret plain", 5'd14, 32'h8000_1000);
    rd("R3 cause plain", 5'd13, 32'h0000_0120);
    rd("R4 mode push", 5'd12, 32'h0000_0034);
  endtask

  task automatic tExcSlot();
    wr(5'd13, 32'h0);
    wr(5'd12, 32'h0040_0003);
    issue(1, 5'd12, 32'h0000_0100, 1, 0, 2'd0, 2'd3, 0, 0);
    chk("R6 flush slot", {31'b0, sFlush}, 1);
    chk("R6 vector boot", sVec, 32'hBFC0_0180);
    rd("R2 ret slot", 5'd14, 32'h0000_00FC);
    rd("R3 cause slot", 5'd13, 32'h8000_0030);
    rd("R4 push keeps bev", 5'd12, 32'h0040_000C);
  endtask

  task automatic tRfe();
    wr(5'd12, 32'h0000_0034);
    issue(0, 0, 0, 0, 1, 2'd0, 2'd2, 0, 0);
    chk("R5 no flush", {31'b0, sFlush}, 0);
    rd("R5 pop", 5'd12, 32'h0000_003D);
  endtask

  task automatic tCu0();
    wr(5'd12, 32'h0);
    wr(5'd3, 32'h1111_1111);
    wr(5'd12, 32'h0000_0002);
    issue(0, 0, 32'h0000_0400, 0, 1, 2'd0, 2'd0, 5'd3, 32'h55);
    chk("R9 flush", {31'b0, sFlush}, 1);
    chk("R9 vector", sVec, 32'h8000_0080);
    rd("R9 cause code", 5'd13, 32'h0000_002C);
    rd("R9 ret", 5'd14, 32'h0000_0400);
    rd("R9 status pushed", 5'd12, 32'h0000_0008);
    rd("R9 write not done", 5'd3, 32'h1111_1111);
    wr(5'd12, 32'h1000_0002);
    issue(0, 0, 0, 0, 1, 2'd0, 2'd0, 5'd3, 32'h22);
    chk("R9 permitted no flush", {31'b0, sFlush}, 0);
    rd("R9 permitted write", 5'd3, 32'h22);
    wr(5'd12, 32'h0);
  endtask

  task automatic tOtherUnit();
    wr(5'd13, 32'h0);
    issue(0, 0, 32'h0000_0500, 0, 1, 2'd2, 2'd1, 5'd12, 0);
    chk("R10 unit2 flush", {31'b0, sFlush}, 1);
    chk("R10 unit2 no load", {31'b0, sLdV}, 0);
    rd("R10 cause", 5'd13, 32'h0000_002C);
    issue(0, 0, 0, 0, 1, 2'd1, 2'd0, 5'd5, 32'h77);
    chk("R10 unit1 flush", {31'b0, sFlush}, 1);
    rd("R10 unit1 no write", 5'd5, 0);
    issue(0, 0, 0, 0, 1, 2'd1, 2'd3, 5'd5, 32'h77);
    chk("R10 op none ignored", {31'b0, sFlush}, 0);
  endtask

  task automatic tCollision();
    wr(5'd5, 32'h0);
    issue(1, 5'd12, 32'h0000_0200, 0, 1, 2'd0, 2'd0, 5'd5, 32'hABCD);
    chk("R11 flush", {31'b0, sFlush}, 1);
    rd("R11 write dropped", 5'd5, 0);
    rd("R11 request code", 5'd13, 32'h0000_0030);
    issue(1, 5'd8, 32'h0000_0300, 0, 1, 2'd0, 2'd1, 5'd5, 0);
    chk("R11 read dropped", {31'b0, sLdV}, 0);
    chk("R11 flush read", {31'b0, sFlush}, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nBad++;
      nChk++;
      $display("FAIL watchdog act=hang exp=done");
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tReset();
    tMasks();
    tMfcTiming();
    tExcPlain();
    tExcSlot();
    tRfe();
    tCu0();
    tOtherUnit();
    tCollision();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule